// File: doc/BRIEF.md
# Dual-Port Variable-Page Translation Buffer

A fully associative buffer of 16 translation entries that maps 32-bit virtual addresses to physical addresses. It has two lookup ports that work at the same time, one for instruction fetch and one for data access. Both lookups are combinational, so both results are ready in the same cycle as their addresses. Every entry covers a pair of adjacent pages, one even and one odd. The entry holds the page size as a mask, an address-space identifier, a global flag, two physical frame numbers, and a valid bit and a dirty bit for each half of the pair.

Software loads entries through a registered write port that takes one entry per cycle. It reads an entry back by index. A combinational probe searches the buffer for a virtual page pair and returns the index of the matching entry, or raises a miss flag. The dirty output is useful only on the data port. The instruction-side copy may be left unconnected.

Top module: `xlat_tlb2`

## Requirements
- R1: The buffer holds `N_ENT` (default 16) entries. Each index can be written on its own, and a lookup can hit an entry at any index, including the first and the last.
- R2: The instruction port and the data port translate independent addresses in the same cycle. If both ports see the same address, they return the same result.
- R3: The per-entry page mask is 16 bits. Mask bit j removes virtual address bit 13+j from the tag compare and passes virtual address bit 12+j through to the physical address. The legal masks are 0x0000, 0x0003, 0x000F, …, 0xFFFF, which give pages of 4 KiB, 16 KiB, …, 256 MiB.
- R4: The lowest virtual address bit above the page offset picks the half of the pair: bit 12 for 4 KiB pages, bit 14 for 16 KiB pages, …, bit 28 for 256 MiB pages. A 0 selects the even half and a 1 selects the odd half. The selected half supplies the frame, the valid bit and the dirty bit.
- R5: An entry matches only if its tag matches and either its identifier equals `asid_i` or its global flag is set.
- R6: On a hit, valid and dirty come from the selected half. On a miss, the hit, valid and dirty outputs and the physical address are all 0.
- R7: The probe returns the index of the lowest matching entry and clears `pr_miss_o`. When no entry matches, `pr_miss_o` is 1 and `pr_idx_o` is 0.
- R8: A write changes nothing in the cycle it is presented. It is visible to lookups, probes and reads from the cycle after the clock edge.
- R9: The read port returns every stored field of the entry at `rd_idx_i`. The flags field is packed as [0] even valid, [1] even dirty, [2] odd valid, [3] odd dirty, and the write port uses the same order.
- R10: Reset clears every field of every entry to 0.
- R11: When several entries match, the lowest index wins, on both lookup ports and on the probe.
- R12: The physical address is `PA_W` bits wide (default 32). Its bits below the page size come from the virtual address, and the bits above come from the selected frame number, which is `PA_W`-12 bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| asid_i | input | ASID_W | Current address-space identifier |
| i_va_i | input | 32 | Instruction-side virtual address |
| i_pa_o | output | PA_W | Instruction-side physical address |
| i_hit_o | output | 1 | Instruction-side match found |
| i_valid_o | output | 1 | Instruction-side valid bit of selected half |
| i_dirty_o | output | 1 | Instruction-side dirty bit (may be left open) |
| d_va_i | input | 32 | Data-side virtual address |
| d_pa_o | output | PA_W | Data-side physical address |
| d_hit_o | output | 1 | Data-side match found |
| d_valid_o | output | 1 | Data-side valid bit of selected half |
| d_dirty_o | output | 1 | Data-side dirty (writable) bit of selected half |
| we_i | input | 1 | Entry write enable |
| wr_idx_i | input | IDX_W | Entry index to write |
| wr_vpn2_i | input | 19 | Virtual page-pair number (VA[31:13]) |
| wr_mask_i | input | 16 | Page mask |
| wr_asid_i | input | ASID_W | Entry identifier |
| wr_global_i | input | 1 | Entry global flag |
| wr_pfn_even_i | input | PA_W-12 | Even-half frame number |
| wr_pfn_odd_i | input | PA_W-12 | Odd-half frame number |
| wr_flags_i | input | 4 | Valid and dirty bits, in the order given in R9 |
| rd_idx_i | input | IDX_W | Entry index to read |
| rd_vpn2_o | output | 19 | Stored page-pair number |
| rd_mask_o | output | 16 | Stored page mask |
| rd_asid_o | output | ASID_W | Stored identifier |
| rd_global_o | output | 1 | Stored global flag |
| rd_pfn_even_o | output | PA_W-12 | Stored even frame |
| rd_pfn_odd_o | output | PA_W-12 | Stored odd frame |
| rd_flags_o | output | 4 | Stored valid/dirty bits |
| pr_vpn2_i | input | 19 | Page-pair number to probe |
| pr_idx_o | output | IDX_W | Index of lowest matching entry |
| pr_miss_o | output | 1 | No entry matched the probe |

## Verification
Lookups are driven with addresses that land in the even and odd halves of a 4 KiB pair, a 16 KiB pair and a 256 MiB pair. This separates a wrong select bit from a wrong offset split. Addresses just outside a 16 KiB pair and in the wrong top region of the large page show whether the mask removes exactly the right compare bits. Identifier mismatches are tried against both a private entry and a global entry, which tells the identifier rule apart from the global override. Duplicate entries, overwritten between two lookups, together with a write observed both before and after its clock edge, expose wrong priority and wrong write timing.

// File: rtl/xlb_pkg.sv
package xlb_pkg;
  localparam int VPN2_W = 19;
  localparam int MASK_W = 16;
  localparam int FLAG_W = 4;
  localparam int F_V_EVEN = 0;
  localparam int F_D_EVEN = 1;
  localparam int F_V_ODD  = 2;
  localparam int F_D_ODD  = 3;

  // va_hi[0] is VA[12]; each set mask pair moves the select bit up by two
  function automatic logic odd_sel(input logic [16:0] va_hi, input logic [MASK_W-1:0] m);
    logic s;
    s = va_hi[0];
    for (int k = 0; k < MASK_W/2; k++)
      if (m[2*k] | m[2*k+1]) s = va_hi[2+2*k];
    return s;
  endfunction
endpackage

// File: rtl/xlb_store.sv
module xlb_store import xlb_pkg::*; #(
  parameter int N_ENT  = 16,
  parameter int ASID_W = 8,
  parameter int PFN_W  = 20,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [VPN2_W-1:0] wr_vpn2_i,
  input  logic [MASK_W-1:0] wr_mask_i,
  input  logic [ASID_W-1:0] wr_asid_i,
  input  logic              wr_global_i,
  input  logic [PFN_W-1:0]  wr_pfn_even_i,
  input  logic [PFN_W-1:0]  wr_pfn_odd_i,
  input  logic [FLAG_W-1:0] wr_flags_i,
  output logic [VPN2_W-1:0] vpn2_o   [N_ENT],
  output logic [MASK_W-1:0] mask_o   [N_ENT],
  output logic [ASID_W-1:0] asid_o   [N_ENT],
  output logic              glob_o   [N_ENT],
  output logic [PFN_W-1:0]  pfn_e_o  [N_ENT],
  output logic [PFN_W-1:0]  pfn_o_o  [N_ENT],
  output logic [FLAG_W-1:0] flags_o  [N_ENT]
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < N_ENT; e++) begin
        vpn2_o[e]  <= '0;
        mask_o[e]  <= '0;
        asid_o[e]  <= '0;
        glob_o[e]  <= 1'b0;
        pfn_e_o[e] <= '0;
        pfn_o_o[e] <= '0;
        flags_o[e] <= '0;
      end
    end else if (we_i) begin
      vpn2_o[wr_idx_i]  <= wr_vpn2_i;
      mask_o[wr_idx_i]  <= wr_mask_i;
      asid_o[wr_idx_i]  <= wr_asid_i;
      glob_o[wr_idx_i]  <= wr_global_i;
      pfn_e_o[wr_idx_i] <= wr_pfn_even_i;
      pfn_o_o[wr_idx_i] <= wr_pfn_odd_i;
      flags_o[wr_idx_i] <= wr_flags_i;
    end
  end

  p_write_lands_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (vpn2_o[$past(wr_idx_i)] == $past(wr_vpn2_i)) &&
             (pfn_e_o[$past(wr_idx_i)] == $past(wr_pfn_even_i)) &&
             (flags_o[$past(wr_idx_i)] == $past(wr_flags_i)));
endmodule

// File: rtl/xlb_match.sv
module xlb_match import xlb_pkg::*; #(
  parameter int N_ENT  = 16,
  parameter int ASID_W = 8,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic [VPN2_W-1:0] vpn2_q_i [N_ENT],
  input  logic [MASK_W-1:0] mask_q_i [N_ENT],
  input  logic [ASID_W-1:0] asid_q_i [N_ENT],
  input  logic              glob_q_i [N_ENT],
  input  logic [VPN2_W-1:0] vpn2_i,
  input  logic [ASID_W-1:0] asid_i,
  output logic              hit_o,
  output logic [IDX_W-1:0]  idx_o
);
  logic [N_ENT-1:0] match;

  for (genvar e = 0; e < N_ENT; e++) begin : g_cmp
    logic [VPN2_W-1:0] keep;
    assign keep     = ~{{(VPN2_W-MASK_W){1'b0}}, mask_q_i[e]};
    assign match[e] = ((vpn2_q_i[e] & keep) == (vpn2_i & keep)) &&
                      (glob_q_i[e] || (asid_q_i[e] == asid_i));
  end

  // lowest index wins
  always_comb begin
    idx_o = '0;
    for (int e = N_ENT-1; e >= 0; e--)
      if (match[e]) idx_o = IDX_W'(e);
  end
  assign hit_o = |match;
endmodule

// File: rtl/xlb_port.sv
module xlb_port import xlb_pkg::*; #(
  parameter int N_ENT  = 16,
  parameter int ASID_W = 8,
  parameter int PA_W   = 32,
  localparam int PFN_W = PA_W - 12,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [VPN2_W-1:0] vpn2_q_i  [N_ENT],
  input  logic [MASK_W-1:0] mask_q_i  [N_ENT],
  input  logic [ASID_W-1:0] asid_q_i  [N_ENT],
  input  logic              glob_q_i  [N_ENT],
  input  logic [PFN_W-1:0]  pfn_e_q_i [N_ENT],
  input  logic [PFN_W-1:0]  pfn_o_q_i [N_ENT],
  input  logic [FLAG_W-1:0] flags_q_i [N_ENT],
  input  logic [ASID_W-1:0] asid_i,
  input  logic [31:0]       va_i,
  output logic [PA_W-1:0]   pa_o,
  output logic              hit_o,
  output logic              valid_o,
  output logic              dirty_o
);
  logic             hit;
  logic [IDX_W-1:0] idx;
  logic             odd;
  logic [MASK_W-1:0] mask_sel;
  logic [PFN_W-1:0]  pfn_sel;
  logic [FLAG_W-1:0] flg;
  logic [PA_W-1:0]   pa_raw;

  xlb_match #(.N_ENT(N_ENT), .ASID_W(ASID_W)) u_match (
    .vpn2_q_i(vpn2_q_i), .mask_q_i(mask_q_i), .asid_q_i(asid_q_i),
    .glob_q_i(glob_q_i), .vpn2_i(va_i[31:13]), .asid_i(asid_i),
    .hit_o(hit), .idx_o(idx)
  );

  assign mask_sel = mask_q_i[idx];
  assign flg      = flags_q_i[idx];
  assign odd      = odd_sel(va_i[28:12], mask_sel);
  assign pfn_sel  = odd ? pfn_o_q_i[idx] : pfn_e_q_i[idx];

  for (genvar b = 0; b < PA_W; b++) begin : g_pa
    if (b < 12) begin : g_off
      assign pa_raw[b] = va_i[b];
    end else if (b < 12 + MASK_W) begin : g_var
      assign pa_raw[b] = mask_sel[b-12] ? va_i[b] : pfn_sel[b-12];
    end else begin : g_frm
      assign pa_raw[b] = pfn_sel[b-12];
    end
  end

  assign hit_o   = hit;
  assign pa_o    = hit ? pa_raw : '0;
  assign valid_o = hit & (odd ? flg[F_V_ODD] : flg[F_V_EVEN]);
  assign dirty_o = hit & (odd ? flg[F_D_ODD] : flg[F_D_EVEN]);

  p_offset_pass_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (pa_o[11:0] == va_i[11:0]));
  p_miss_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (!valid_o && !dirty_o && pa_o == '0));
endmodule

// File: rtl/xlat_tlb2.sv
module xlat_tlb2 import xlb_pkg::*; #(
  parameter int N_ENT  = 16,
  parameter int ASID_W = 8,
  parameter int PA_W   = 32,
  localparam int PFN_W = PA_W - 12,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ASID_W-1:0] asid_i,
  input  logic [31:0]       i_va_i,
  output logic [PA_W-1:0]   i_pa_o,
  output logic              i_hit_o,
  output logic              i_valid_o,
  output logic              i_dirty_o,
  input  logic [31:0]       d_va_i,
  output logic [PA_W-1:0]   d_pa_o,
  output logic              d_hit_o,
  output logic              d_valid_o,
  output logic              d_dirty_o,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [18:0]       wr_vpn2_i,
  input  logic [15:0]       wr_mask_i,
  input  logic [ASID_W-1:0] wr_asid_i,
  input  logic              wr_global_i,
  input  logic [PFN_W-1:0]  wr_pfn_even_i,
  input  logic [PFN_W-1:0]  wr_pfn_odd_i,
  input  logic [3:0]        wr_flags_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [18:0]       rd_vpn2_o,
  output logic [15:0]       rd_mask_o,
  output logic [ASID_W-1:0] rd_asid_o,
  output logic              rd_global_o,
  output logic [PFN_W-1:0]  rd_pfn_even_o,
  output logic [PFN_W-1:0]  rd_pfn_odd_o,
  output logic [3:0]        rd_flags_o,
  input  logic [18:0]       pr_vpn2_i,
  output logic [IDX_W-1:0]  pr_idx_o,
  output logic              pr_miss_o
);
  logic [VPN2_W-1:0] e_vpn2  [N_ENT];
  logic [MASK_W-1:0] e_mask  [N_ENT];
  logic [ASID_W-1:0] e_asid  [N_ENT];
  logic              e_glob  [N_ENT];
  logic [PFN_W-1:0]  e_pfn_e [N_ENT];
  logic [PFN_W-1:0]  e_pfn_o [N_ENT];
  logic [FLAG_W-1:0] e_flags [N_ENT];
  logic              pr_hit;
  logic [IDX_W-1:0]  pr_idx;

  xlb_store #(.N_ENT(N_ENT), .ASID_W(ASID_W), .PFN_W(PFN_W)) u_store (
    .clk_i, .rst_ni, .we_i, .wr_idx_i, .wr_vpn2_i, .wr_mask_i, .wr_asid_i,
    .wr_global_i, .wr_pfn_even_i, .wr_pfn_odd_i, .wr_flags_i,
    .vpn2_o(e_vpn2), .mask_o(e_mask), .asid_o(e_asid), .glob_o(e_glob),
    .pfn_e_o(e_pfn_e), .pfn_o_o(e_pfn_o), .flags_o(e_flags)
  );

  xlb_port #(.N_ENT(N_ENT), .ASID_W(ASID_W), .PA_W(PA_W)) u_iport (
    .clk_i, .rst_ni, .vpn2_q_i(e_vpn2), .mask_q_i(e_mask), .asid_q_i(e_asid),
    .glob_q_i(e_glob), .pfn_e_q_i(e_pfn_e), .pfn_o_q_i(e_pfn_o), .flags_q_i(e_flags),
    .asid_i, .va_i(i_va_i), .pa_o(i_pa_o), .hit_o(i_hit_o),
    .valid_o(i_valid_o), .dirty_o(i_dirty_o)
  );

  xlb_port #(.N_ENT(N_ENT), .ASID_W(ASID_W), .PA_W(PA_W)) u_dport (
    .clk_i, .rst_ni, .vpn2_q_i(e_vpn2), .mask_q_i(e_mask), .asid_q_i(e_asid),
    .glob_q_i(e_glob), .pfn_e_q_i(e_pfn_e), .pfn_o_q_i(e_pfn_o), .flags_q_i(e_flags),
    .asid_i, .va_i(d_va_i), .pa_o(d_pa_o), .hit_o(d_hit_o),
    .valid_o(d_valid_o), .dirty_o(d_dirty_o)
  );

  xlb_match #(.N_ENT(N_ENT), .ASID_W(ASID_W)) u_probe (
    .vpn2_q_i(e_vpn2), .mask_q_i(e_mask), .asid_q_i(e_asid), .glob_q_i(e_glob),
    .vpn2_i(pr_vpn2_i), .asid_i, .hit_o(pr_hit), .idx_o(pr_idx)
  );

  assign pr_miss_o = ~pr_hit;
  assign pr_idx_o  = pr_hit ? pr_idx : '0;

  assign rd_vpn2_o     = e_vpn2[rd_idx_i];
  assign rd_mask_o     = e_mask[rd_idx_i];
  assign rd_asid_o     = e_asid[rd_idx_i];
  assign rd_global_o   = e_glob[rd_idx_i];
  assign rd_pfn_even_o = e_pfn_e[rd_idx_i];
  assign rd_pfn_odd_o  = e_pfn_o[rd_idx_i];
  assign rd_flags_o    = e_flags[rd_idx_i];

  p_ports_agree_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (i_va_i == d_va_i) |-> (i_pa_o == d_pa_o && i_hit_o == d_hit_o &&
                            i_valid_o == d_valid_o && i_dirty_o == d_dirty_o));
  p_probe_agree_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pr_vpn2_i == d_va_i[31:13]) |-> (pr_miss_o == !d_hit_o));
endmodule

// File: tb/xlat_tlb2_bench.sv
module xlat_tlb2_bench;
  localparam int PA_W = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  asid = '0;
  logic [31:0] i_va = '0, d_va = '0;
  logic [31:0] i_pa, d_pa;
  logic        i_hit, i_valid, i_dirty, d_hit, d_valid, d_dirty;
  logic        we = 1'b0;
  logic [3:0]  wr_idx = '0, rd_idx = '0, pr_idx;
  logic [18:0] wr_vpn2 = '0, rd_vpn2, pr_vpn2 = '0;
  logic [15:0] wr_mask = '0, rd_mask;
  logic [7:0]  wr_asid = '0, rd_asid;
  logic        wr_g = 1'b0, rd_g, pr_miss;
  logic [19:0] wr_pe = '0, wr_po = '0, rd_pe, rd_po;
  logic [3:0]  wr_fl = '0, rd_fl;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  xlat_tlb2 u_xlat_tlb2 (
    .clk_i(clk), .rst_ni(rst_n), .asid_i(asid),
    .i_va_i(i_va), .i_pa_o(i_pa), .i_hit_o(i_hit), .i_valid_o(i_valid), .i_dirty_o(i_dirty),
    .d_va_i(d_va), .d_pa_o(d_pa), .d_hit_o(d_hit), .d_valid_o(d_valid), .d_dirty_o(d_dirty),
    .we_i(we), .wr_idx_i(wr_idx), .wr_vpn2_i(wr_vpn2), .wr_mask_i(wr_mask),
    .wr_asid_i(wr_asid), .wr_global_i(wr_g), .wr_pfn_even_i(wr_pe), .wr_pfn_odd_i(wr_po),
    .wr_flags_i(wr_fl), .rd_idx_i(rd_idx), .rd_vpn2_o(rd_vpn2), .rd_mask_o(rd_mask),
    .rd_asid_o(rd_asid), .rd_global_o(rd_g), .rd_pfn_even_o(rd_pe), .rd_pfn_odd_o(rd_po),
    .rd_flags_o(rd_fl), .pr_vpn2_i(pr_vpn2), .pr_idx_o(pr_idx), .pr_miss_o(pr_miss)
  );

  typedef struct packed {
    logic [31:0] va; logic [7:0] asid; logic hit; logic [31:0] pa; logic v; logic d;
  } vec_t;

  localparam vec_t VEC [10] = '{
    '{32'h0000_0123, 8'd5, 1'b1, 32'h1111_1123, 1'b1, 1'b0},  // 4K even
    '{32'h0000_1ABC, 8'd5, 1'b1, 32'h2222_2ABC, 1'b1, 1'b1},  // 4K odd
    '{32'h0000_0123, 8'd6, 1'b0, 32'h0000_0000, 1'b0, 1'b0},  // asid miss
    '{32'h1000_2345, 8'd9, 1'b1, 32'h4000_2345, 1'b1, 1'b1},  // global 16K even
    '{32'h1000_5678, 8'd9, 1'b1, 32'h4000_9678, 1'b0, 1'b0},  // 16K odd, invalid half
    '{32'h1000_8000, 8'd9, 1'b0, 32'h0000_0000, 1'b0, 1'b0},  // beyond 16K pair
    '{32'h8123_4567, 8'd7, 1'b1, 32'h0123_4567, 1'b1, 1'b1},  // 256M even
    '{32'h9234_5678, 8'd7, 1'b1, 32'h1234_5678, 1'b1, 1'b1},  // 256M odd
    '{32'hF000_0000, 8'd7, 1'b0, 32'h0000_0000, 1'b0, 1'b0},  // wrong region
    '{32'h8000_0000, 8'd8, 1'b0, 32'h0000_0000, 1'b0, 1'b0}   // asid miss
  };

  task automatic chk(input string req, input string what, input logic [35:0] got, input logic [35:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic put(input logic [3:0] idx, input logic [18:0] vpn2, input logic [15:0] mask,
                     input logic [7:0] as, input logic g, input logic [19:0] pe,
                     input logic [19:0] po, input logic [3:0] fl);
    @(negedge clk);
    we = 1'b1; wr_idx = idx; wr_vpn2 = vpn2; wr_mask = mask; wr_asid = as;
    wr_g = g; wr_pe = pe; wr_po = po; wr_fl = fl;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic look(input logic [31:0] iva, input logic [31:0] dva, input logic [7:0] as);
    @(negedge clk);
    i_va = iva; d_va = dva; asid = as;
    #2;
  endtask

  initial begin
    #(20 * 100000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    // R10: reset state
    rd_idx = 4'd0; #1;
    chk("R10", "rd0 vpn2", rd_vpn2, 0); chk("R10", "rd0 pfn", rd_pe, 0);
    chk("R10", "rd0 flags", rd_fl, 0);
    rd_idx = 4'd15; #1;
    chk("R10", "rd15 mask", rd_mask, 0); chk("R10", "rd15 g", rd_g, 0);
    look(32'h0000_2000, 32'h0000_2000, 8'd3);
    chk("R10", "lookup miss", i_hit, 0);
    pr_vpn2 = 19'd0; #1;
    chk("R10", "probe miss", pr_miss, 1);

    // R8: write is invisible before the edge, visible after
    look(32'h0000_0123, 32'h0000_0123, 8'd5);
    @(negedge clk);
    we = 1'b1; wr_idx = 4'd0; wr_vpn2 = 19'h0; wr_mask = 16'h0; wr_asid = 8'd5;
    wr_g = 1'b0; wr_pe = 20'h11111; wr_po = 20'h22222; wr_fl = 4'b1101;
    #1;
    chk("R8", "before edge", i_hit, 0);
    @(posedge clk); #1;
    chk("R8", "after edge hit", i_hit, 1);
    chk("R8", "after edge pa", i_pa, 36'h1111_1123);
    @(negedge clk); we = 1'b0;

    put(4'd7,  19'h00000, 16'h0000, 8'd5, 1'b0, 20'h33333, 20'h44444, 4'b0001);
    put(4'd3,  19'h08000, 16'h0003, 8'd5, 1'b1, 20'h40000, 20'h40008, 4'b0011);
    put(4'd15, 19'h40000, 16'hFFFF, 8'd7, 1'b0, 20'h00000, 20'h10000, 4'b1111);

    // R1 R3 R4 R5 R6 R12: table on both ports
    for (int n = 0; n < 10; n++) begin
      look(VEC[n].va, VEC[n].va, VEC[n].asid);
      chk("R3 R4 R5", $sformatf("i hit v%0d", n), i_hit, VEC[n].hit);
      chk("R12", $sformatf("i pa v%0d", n), i_pa, VEC[n].pa);
      chk("R6", $sformatf("i valid v%0d", n), i_valid, VEC[n].v);
      chk("R6", $sformatf("i dirty v%0d", n), i_dirty, VEC[n].d);
      chk("R1 R2", $sformatf("d hit v%0d", n), d_hit, VEC[n].hit);
      chk("R12", $sformatf("d pa v%0d", n), d_pa, VEC[n].pa);
      chk("R6", $sformatf("d valid v%0d", n), d_valid, VEC[n].v);
      chk("R6", $sformatf("d dirty v%0d", n), d_dirty, VEC[n].d);
    end

    // R2: different addresses in the same cycle
    look(32'h1000_2345, 32'h9234_5678, 8'd7);
    chk("R2", "i pa", i_pa, 36'h4000_2345);
    chk("R2", "d pa", d_pa, 36'h1234_5678);
    chk("R2", "d hit", d_hit, 1);

    // R7: probe
    pr_vpn2 = 19'h00000; asid = 8'd5; #1;
    chk("R7", "probe dup idx", pr_idx, 0); chk("R7", "probe dup miss", pr_miss, 0);
    pr_vpn2 = 19'h08001; asid = 8'd2; #1;
    chk("R7", "probe 16K idx", pr_idx, 3);
    pr_vpn2 = 19'h7FFFF; asid = 8'd5; #1;
    chk("R7", "probe miss", pr_miss, 1); chk("R7", "probe miss idx", pr_idx, 0);

    // R9: readback
    rd_idx = 4'd3; #1;
    chk("R9", "vpn2", rd_vpn2, 36'h08000); chk("R9", "mask", rd_mask, 36'h3);
    chk("R9", "asid", rd_asid, 5); chk("R9", "g", rd_g, 1);
    chk("R9", "pfn even", rd_pe, 36'h40000); chk("R9", "pfn odd", rd_po, 36'h40008);
    chk("R9", "flags", rd_fl, 36'h3);

    // R11: duplicate entries, lowest index wins; retire entry 0 to expose entry 7
    put(4'd0, 19'h00000, 16'h0000, 8'd6, 1'b0, 20'h11111, 20'h22222, 4'b1101);
    look(32'h0000_0123, 32'h0000_0123, 8'd5);
    chk("R11", "fallback pa", d_pa, 36'h3333_3123);
    chk("R11", "fallback dirty", d_dirty, 0);
    pr_vpn2 = 19'h00000; #1;
    chk("R11", "probe idx", pr_idx, 7);
    asid = 8'd6; #1;
    chk("R11", "probe idx asid6", pr_idx, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule